// File: doc/BRIEF.md
# Per-Bank Precharge Timing Guard

This block sits inside a DDR2 memory controller next to the command scheduler. It watches each command the scheduler issues and keeps one timer per bank. The timer gives the earliest clock edge at which a precharge to that bank may legally be issued. From these timers it produces a ready flag for each bank and a combined flag for precharge-all. The scheduler consults these flags before it issues a precharge.

Read-side and write-side commands give different minimum spacings. Reads use additive latency, half the burst length and the read-to-precharge time, and that time never counts as less than two clocks. Writes use write latency, half the burst length and write recovery. A newer command can only lengthen a bank's wait and never shortens it.

A second per-bank flag reports when the precharge period of that bank has elapsed. The period is timed from the most recent precharge that touched the bank. It lasts the row precharge time after a single-bank precharge and one clock more after a precharge-all.

All latency settings are static. They are set while reset is asserted and held constant afterwards.

Top module: `ddr2_pg_top`

## Requirements
- R1: After a read (op 2) or read with auto-precharge (op 3) to a bank at edge t, a precharge to that bank is first allowed at edge t+D. D = AL + H + max(RTP,2) - 2, where H is 2 when cfg_bl8=0 and 4 when cfg_bl8=1.
- R2: A programmed read-to-precharge value of 0 or 1 clock counts as 2 clocks in the R1 spacing.
- R3: After a write (op 4) or write with auto-precharge (op 5) to a bank at edge t, a precharge to that bank is first allowed at edge t+D, where D = WL + H + WR.
- R4: The ready flags are registered. After a command at edge t whose spacing is D, bank_ready of that bank is low in the cycles following edges t..t+D-2 and high in the cycle following edge t+D-1.
- R5: A bank's remaining wait is the maximum of the wait it already had and the requirement of the newest command. A shorter requirement never shortens the wait.
- R6: A precharge (op 6) or precharge-all (op 7) never lowers a ready flag, so a further precharge is allowed one clock later.
- R7: all_ready is high exactly when every bank_ready bit is high.
- R8: period_done of a bank goes low after a precharge to it (op 6) or a precharge-all (op 7). It is first high again RP clocks after a single-bank precharge and RP+1 clocks after a precharge-all, both counted from the latest such command, which restarts the period even if the new period is shorter.
- R9: Op 0 (no operation) and op 1 (activate) change no output.
- R10: While reset is active and right after reset, every bank_ready bit, all_ready and every period_done bit are high.
- R11: A bank-specific command changes no flag of any other bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_al | input | CFG_W | Additive latency in clocks |
| cfg_wl | input | CFG_W | Write latency in clocks |
| cfg_bl8 | input | 1 | Burst length select: 0 = 4, 1 = 8 |
| cfg_wr | input | CFG_W | Write recovery in clocks |
| cfg_rp | input | CFG_W | Row precharge time in clocks |
| cfg_rtp | input | CFG_W | Read-to-precharge time in clocks (already rounded up) |
| cmd_op | input | 3 | Command code: 0 nop, 1 activate, 2 read, 3 read+AP, 4 write, 5 write+AP, 6 precharge, 7 precharge-all |
| cmd_bank | input | BANK_W | Bank address of the command |
| bank_ready | output | NUM_BANKS | Per-bank: precharge may be issued at the next edge |
| all_ready | output | 1 | Precharge-all may be issued at the next edge |
| period_done | output | NUM_BANKS | Per-bank: precharge period has elapsed |

## Verification
The assertions assume that the configuration inputs stay constant while reset is released. They also assume that commands start only after the internal reset has been released. The stimulus follows both assumptions. It changes the configuration only while reset is held, and it waits several clocks after releasing reset before it issues anything. The single-bank precharge check also assumes that the scheduler issues a precharge only to a bank whose flag is ready. Every precharge the stimulus issues goes to a bank that has drained, or the precharge is a precharge-all.

// File: rtl/ddr2_pg_pkg.sv
package ddr2_pg_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_RDA  = 3'd3,
    OP_WR   = 3'd4,
    OP_WRA  = 3'd5,
    OP_PRE  = 3'd6,
    OP_PREA = 3'd7
  } pg_op_e;

  localparam int RTP_FLOOR = 2;

endpackage

// File: rtl/ddr2_pg_delay_calc.sv
module ddr2_pg_delay_calc #(
  parameter int CFG_W = 4,
  parameter int CNT_W = CFG_W + 2
) (
  input  logic [CFG_W-1:0] cfg_al,
  input  logic [CFG_W-1:0] cfg_wl,
  input  logic             cfg_bl8,
  input  logic [CFG_W-1:0] cfg_wr,
  input  logic [CFG_W-1:0] cfg_rp,
  input  logic [CFG_W-1:0] cfg_rtp,
  output logic [CNT_W-1:0] rd_load,
  output logic [CNT_W-1:0] wr_load,
  output logic [CNT_W-1:0] rp_one_load,
  output logic [CNT_W-1:0] rp_all_load
);
  import ddr2_pg_pkg::*;

  logic [CNT_W-1:0] half_burst;
  logic [CNT_W-1:0] rtp_eff;

  // Load values are one less than the spacing in clocks, since the
  // counter reaches zero one edge ahead of the allowed edge.
  always_comb begin
    half_burst = cfg_bl8 ? CNT_W'(4) : CNT_W'(2);
    rtp_eff    = (cfg_rtp < CFG_W'(RTP_FLOOR)) ? CNT_W'(RTP_FLOOR) : CNT_W'(cfg_rtp);
    rd_load    = CNT_W'(cfg_al) + half_burst + rtp_eff - CNT_W'(3);
    wr_load    = CNT_W'(cfg_wl) + half_burst + CNT_W'(cfg_wr) - CNT_W'(1);
    rp_one_load = (cfg_rp == '0) ? '0 : CNT_W'(cfg_rp) - CNT_W'(1);
    rp_all_load = CNT_W'(cfg_rp);
  end

endmodule

// File: rtl/ddr2_pg_cmd_decode.sv
module ddr2_pg_cmd_decode #(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic [2:0]           cmd_op,
  input  logic [BANK_W-1:0]    cmd_bank,
  output logic [NUM_BANKS-1:0] rd_hit,
  output logic [NUM_BANKS-1:0] wr_hit,
  output logic [NUM_BANKS-1:0] pre_one_hit,
  output logic                 pre_all
);
  import ddr2_pg_pkg::*;

  logic [NUM_BANKS-1:0] bank_sel;

  always_comb begin
    bank_sel    = NUM_BANKS'(1) << cmd_bank;
    rd_hit      = '0;
    wr_hit      = '0;
    pre_one_hit = '0;
    pre_all     = 1'b0;
    case (pg_op_e'(cmd_op))
      OP_RD, OP_RDA: rd_hit      = bank_sel;
      OP_WR, OP_WRA: wr_hit      = bank_sel;
      OP_PRE:        pre_one_hit = bank_sel;
      OP_PREA:       pre_all     = 1'b1;
      default:       ;
    endcase
  end

endmodule

// File: rtl/ddr2_pg_bank_timer.sv
module ddr2_pg_bank_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_hit,
  input  logic             wr_hit,
  input  logic             pre_one_hit,
  input  logic             pre_all,
  input  logic [CNT_W-1:0] rd_load,
  input  logic [CNT_W-1:0] wr_load,
  input  logic [CNT_W-1:0] rp_one_load,
  input  logic [CNT_W-1:0] rp_all_load,
  output logic             ready,
  output logic             period_done
);

  logic [CNT_W-1:0] pre_cnt_q, pre_cnt_d;
  logic [CNT_W-1:0] rp_cnt_q, rp_cnt_d;
  logic [CNT_W-1:0] pre_dec, rp_dec, need;
  logic             pre_en, rp_en;

  // Precharge-spacing counter: decrements to zero, raised only by max.
  always_comb begin
    pre_dec = (pre_cnt_q == '0) ? '0 : pre_cnt_q - CNT_W'(1);
    if (rd_hit)      need = rd_load;
    else if (wr_hit) need = wr_load;
    else             need = '0;
    pre_cnt_d = (need > pre_dec) ? need : pre_dec;
    pre_en    = (pre_cnt_q != '0) || rd_hit || wr_hit;
  end

  // Precharge-period counter: restarted by the latest precharge.
  always_comb begin
    rp_dec = (rp_cnt_q == '0) ? '0 : rp_cnt_q - CNT_W'(1);
    if (pre_one_hit)  rp_cnt_d = rp_one_load;
    else if (pre_all) rp_cnt_d = rp_all_load;
    else              rp_cnt_d = rp_dec;
    rp_en = (rp_cnt_q != '0) || pre_one_hit || pre_all;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt_q <= '0;
      rp_cnt_q  <= '0;
    end else begin
      if (pre_en) pre_cnt_q <= pre_cnt_d;
      if (rp_en)  rp_cnt_q  <= rp_cnt_d;
    end
  end

  assign ready       = (pre_cnt_q == '0);
  assign period_done = (rp_cnt_q == '0);

endmodule

// File: rtl/ddr2_pg_top.sv
module ddr2_pg_top #(
  parameter  int NUM_BANKS = 8,
  parameter  int CFG_W     = 4,
  localparam int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CFG_W-1:0]     cfg_al,
  input  logic [CFG_W-1:0]     cfg_wl,
  input  logic                 cfg_bl8,
  input  logic [CFG_W-1:0]     cfg_wr,
  input  logic [CFG_W-1:0]     cfg_rp,
  input  logic [CFG_W-1:0]     cfg_rtp,
  input  logic [2:0]           cmd_op,
  input  logic [BANK_W-1:0]    cmd_bank,
  output logic [NUM_BANKS-1:0] bank_ready,
  output logic                 all_ready,
  output logic [NUM_BANKS-1:0] period_done
);

  localparam int CNT_W = CFG_W + 2;

  logic rst_meta_q, rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  logic [CNT_W-1:0]     rd_load, wr_load, rp_one_load, rp_all_load;
  logic [NUM_BANKS-1:0] rd_hit, wr_hit, pre_one_hit;
  logic                 pre_all;

  ddr2_pg_delay_calc #(.CFG_W(CFG_W), .CNT_W(CNT_W)) u_calc (
    .cfg_al      (cfg_al),
    .cfg_wl      (cfg_wl),
    .cfg_bl8     (cfg_bl8),
    .cfg_wr      (cfg_wr),
    .cfg_rp      (cfg_rp),
    .cfg_rtp     (cfg_rtp),
    .rd_load     (rd_load),
    .wr_load     (wr_load),
    .rp_one_load (rp_one_load),
    .rp_all_load (rp_all_load)
  );

  ddr2_pg_cmd_decode #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_dec (
    .cmd_op      (cmd_op),
    .cmd_bank    (cmd_bank),
    .rd_hit      (rd_hit),
    .wr_hit      (wr_hit),
    .pre_one_hit (pre_one_hit),
    .pre_all     (pre_all)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ddr2_pg_bank_timer #(.CNT_W(CNT_W)) u_timer (
      .clk         (clk),
      .rst_n       (rst_q_n),
      .rd_hit      (rd_hit[b]),
      .wr_hit      (wr_hit[b]),
      .pre_one_hit (pre_one_hit[b]),
      .pre_all     (pre_all),
      .rd_load     (rd_load),
      .wr_load     (wr_load),
      .rp_one_load (rp_one_load),
      .rp_all_load (rp_all_load),
      .ready       (bank_ready[b]),
      .period_done (period_done[b])
    );
  end

  assign all_ready = &bank_ready;

endmodule

// File: rtl/ddr2_pg_checker.sv
module ddr2_pg_checker #(
  parameter int NUM_BANKS = 8,
  parameter int CFG_W     = 4,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CFG_W-1:0]     cfg_rp,
  input logic [2:0]           cmd_op,
  input logic [BANK_W-1:0]    cmd_bank,
  input logic [NUM_BANKS-1:0] bank_ready,
  input logic                 all_ready,
  input logic [NUM_BANKS-1:0] period_done
);

  logic [NUM_BANKS-1:0] fell;
  logic [NUM_BANKS-1:0] ready_prev;
  logic [2:0]           op_prev;
  logic [BANK_W-1:0]    bank_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_prev <= '1;
      op_prev    <= 3'd0;
      bank_prev  <= '0;
    end else begin
      ready_prev <= bank_ready;
      op_prev    <= cmd_op;
      bank_prev  <= cmd_bank;
    end
  end

  assign fell = ready_prev & ~bank_ready;

  // R1: a read blocks its bank on the next cycle
  a_r1_read_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd2 || cmd_op == 3'd3) |=> !bank_ready[$past(cmd_bank)]);

  // R3: a write blocks its bank on the next cycle
  a_r3_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd4 || cmd_op == 3'd5) |=> !bank_ready[$past(cmd_bank)]);

  // R6: precharge to a ready bank leaves it ready
  a_r6_pre_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd6 && bank_ready[cmd_bank]) |=> bank_ready[$past(cmd_bank)]);

  // R7: precharge-all with all banks ready keeps them ready
  a_r7_prea_keeps_all: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd7 && all_ready) |=> all_ready);

  // R8: precharge-all opens a period in every bank
  a_r8_prea_period: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd7 && cfg_rp != '0) |=> (period_done == '0));

  // R9: activate with everything ready changes nothing
  a_r9_act_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd1 && all_ready) |=> all_ready);

  // R11: a ready flag falls only in the bank a read or write addressed
  a_r11_fall_source: assert property (@(posedge clk) disable iff (!rst_n)
    (fell != '0) |-> ((op_prev >= 3'd2 && op_prev <= 3'd5) &&
                      fell == (NUM_BANKS'(1) << bank_prev)));

endmodule

bind ddr2_pg_top ddr2_pg_checker #(
  .NUM_BANKS(NUM_BANKS), .CFG_W(CFG_W), .BANK_W(BANK_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .cfg_rp      (cfg_rp),
  .cmd_op      (cmd_op),
  .cmd_bank    (cmd_bank),
  .bank_ready  (bank_ready),
  .all_ready   (all_ready),
  .period_done (period_done)
);

// File: tb/tb_ddr2_pg_top.sv
module tb_ddr2_pg_top;

  localparam int NB = 8;
  localparam int CW = 4;
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_RDA = 3'd3,
                         C_WR = 3'd4, C_WRA = 3'd5, C_PRE = 3'd6, C_PREA = 3'd7;

  logic          clk, rst_n;
  logic [CW-1:0] cfg_al, cfg_wl, cfg_wr, cfg_rp, cfg_rtp;
  logic          cfg_bl8;
  logic [2:0]    cmd_op;
  logic [2:0]    cmd_bank;
  logic [NB-1:0] bank_ready, period_done;
  logic          all_ready;

  int checks = 0;
  int fails  = 0;

  ddr2_pg_top #(.NUM_BANKS(NB), .CFG_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_al(cfg_al), .cfg_wl(cfg_wl),
    .cfg_bl8(cfg_bl8), .cfg_wr(cfg_wr), .cfg_rp(cfg_rp), .cfg_rtp(cfg_rtp),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank), .bank_ready(bank_ready),
    .all_ready(all_ready), .period_done(period_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // sel: 0 = bank_ready of bank 3, 1 = period_done of bank 3
  typedef struct packed {
    logic [2:0] op;
    logic [3:0] al, wl;
    logic       bl8;
    logic [3:0] wr, rp, rtp;
    logic [1:0] sel;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t TBL [11] = '{
    '{C_RD,   4'd0,  4'd0,  1'b0, 4'd0,  4'd3, 4'd2,  2'd0, 8'd2},   // R1
    '{C_RD,   4'd0,  4'd0,  1'b0, 4'd0,  4'd3, 4'd0,  2'd0, 8'd2},   // R2
    '{C_RD,   4'd1,  4'd0,  1'b0, 4'd0,  4'd3, 4'd1,  2'd0, 8'd3},   // R2
    '{C_RDA,  4'd2,  4'd0,  1'b1, 4'd0,  4'd3, 4'd3,  2'd0, 8'd7},   // R1
    '{C_WR,   4'd0,  4'd3,  1'b0, 4'd3,  4'd3, 4'd2,  2'd0, 8'd8},   // R3
    '{C_WRA,  4'd0,  4'd5,  1'b1, 4'd6,  4'd3, 4'd2,  2'd0, 8'd15},  // R3
    '{C_RD,   4'd15, 4'd0,  1'b1, 4'd0,  4'd3, 4'd15, 2'd0, 8'd32},  // R1
    '{C_WR,   4'd0,  4'd15, 1'b1, 4'd15, 4'd3, 4'd2,  2'd0, 8'd34},  // R3
    '{C_PRE,  4'd0,  4'd3,  1'b0, 4'd3,  4'd4, 4'd2,  2'd0, 8'd1},   // R6
    '{C_PRE,  4'd0,  4'd3,  1'b0, 4'd3,  4'd4, 4'd2,  2'd1, 8'd4},   // R8
    '{C_PREA, 4'd0,  4'd3,  1'b0, 4'd3,  4'd4, 4'd2,  2'd1, 8'd5}    // R8
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input int al, input int wl, input int bl8, input int wr,
                       input int rp, input int rtp);
    @(negedge clk);
    rst_n    = 1'b0;
    cmd_op   = C_NOP;
    cmd_bank = '0;
    cfg_al = CW'(al); cfg_wl = CW'(wl); cfg_bl8 = bl8[0];
    cfg_wr = CW'(wr); cfg_rp = CW'(rp); cfg_rtp = CW'(rtp);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Drive one command for one edge; returns at the following negedge.
  task automatic drive(input logic [2:0] op, input int bank);
    cmd_op   = op;
    cmd_bank = 3'(bank);
    @(negedge clk);
    cmd_op = C_NOP;
  endtask

  // Offset (in edges after the last command) of the first allowed edge.
  task automatic measure(input int sel, input int bank, output int off);
    off = 99;
    for (int k = 0; k < 64; k++) begin
      if ((sel == 0 && bank_ready[bank]) || (sel == 1 && period_done[bank]) ||
          (sel == 2 && all_ready)) begin
        off = k + 1;
        return;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int off;
    rst_n = 1'b0;
    cmd_op = C_NOP; cmd_bank = '0;
    cfg_al = '0; cfg_wl = '0; cfg_bl8 = 1'b0; cfg_wr = '0; cfg_rp = '0; cfg_rtp = '0;

    // Vector table
    for (int i = 0; i < 11; i++) begin
      setup(int'(TBL[i].al), int'(TBL[i].wl), int'(TBL[i].bl8), int'(TBL[i].wr),
            int'(TBL[i].rp), int'(TBL[i].rtp));
      drive(TBL[i].op, 3);
      // R11: bank 5 untouched by a bank-3 command
      if (TBL[i].op != C_PREA) begin
        check(bank_ready[5] && period_done[5], "R11 other bank", int'({bank_ready[5], period_done[5]}), 3);
      end
      measure(int'(TBL[i].sel), 3, off);
      check(off == int'(TBL[i].exp), $sformatf("R4 vector %0d", i), off, int'(TBL[i].exp));
    end

    // R10: reset state
    setup(0, 3, 0, 3, 6, 2);
    check(bank_ready == '1 && all_ready && period_done == '1, "R10 reset",
          int'({bank_ready, all_ready, period_done}), 131071);

    // R9: activate changes nothing
    drive(C_ACT, 1);
    check(bank_ready == '1 && period_done == '1, "R9 activate", int'({bank_ready, period_done}), 65535);
    @(negedge clk);
    check(all_ready && period_done == '1, "R9 activate later", int'({all_ready, period_done}), 511);

    // R5: write then shorter read; read spacing 2, write spacing 8
    setup(0, 3, 0, 3, 6, 2);
    drive(C_WR, 2);
    drive(C_RD, 2);
    measure(0, 2, off);
    check(off == 7, "R5 raise only", off, 7);

    // R7: precharge-all after a write keeps the write wait
    setup(0, 3, 0, 3, 6, 2);
    drive(C_WR, 2);
    drive(C_PREA, 0);
    check(!all_ready && bank_ready[4], "R7 all_ready low", int'({all_ready, bank_ready[4]}), 1);
    measure(2, 0, off);
    check(off == 7, "R7 all_ready timing", off, 7);

    // R8: precharge-all after precharge restarts longer period
    setup(0, 3, 0, 3, 6, 2);
    drive(C_PRE, 3);
    drive(C_NOP, 0);
    drive(C_NOP, 0);
    drive(C_PREA, 0);
    measure(1, 3, off);
    check(off == 7, "R8 restart by precharge-all", off, 7);

    // R8: precharge after precharge-all restarts a shorter period
    setup(0, 3, 0, 3, 6, 2);
    drive(C_PREA, 0);
    drive(C_PRE, 3);
    check(!period_done[4], "R8 other bank still in period", int'(period_done[4]), 0);
    measure(1, 3, off);
    check(off == 6, "R8 restart by precharge", off, 6);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule